// File: doc/BRIEF.md
# SD Multi-Block Data Engine

This block carries the data phase of an SD card transfer. It moves one or more equal-sized blocks over the DAT lines, in either 1-bit or 4-bit mode, toward the card or away from it. Software-side logic supplies the block count minus one, the per-block bit count, the bus width, a transfer direction, the write gap and the expected card status token, then pulses `start`. Write payload bytes are pulled from a byte stream with a valid/ready handshake. Read payload bytes are pushed out as one-cycle `rd_valid` strobes.

On reads, every active lane carries its own 16-bit CRC, which the engine checks. On writes, the engine generates and appends a CRC per lane. It then listens for the card's 3-bit status token on DAT0 and waits for DAT0 to return high before it starts the next block. At the end of a transfer, one of two status bits reports whether all CRCs of a read, or all tokens of a write, were good. The DAT lines advance by one bit per clock cycle. Command issue and clock division are handled elsewhere.

Top module: `sd_block_mover`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low and exactly one of `xfer_wr` or `xfer_rd` is high. In any other case it is ignored: `busy` stays low and the DAT lines stay undriven.
- R2: A transfer moves `blk_cnt_m1`+1 blocks, so the value 255 gives 256 blocks.
- R3: Each block carries P/8 payload bytes, where P = `blk_bits` − 15·L and L is 4 in 4-bit mode or 1 in 1-bit mode. A write pulls exactly (`blk_cnt_m1`+1)·P/8 bytes from the write stream.
- R4: In 1-bit mode (`wide4`=0), only DAT0 is used, and each byte is sent or received MSB first. In 4-bit mode, each byte takes two cycles: bits 7:4 first, then bits 3:0, with the higher bit of each nibble on the higher lane.
- R5: A read block begins in the cycle after all active lanes are sampled low. Its payload bytes come out on `rd_data` with `rd_valid`, in the order the card sent them.
- R6: At the end of a read, `rd_crc_ok` is high only if every block's CRC16 matched on every active lane. The CRC uses the polynomial 0x1021, starts from zero and is sent MSB first after the lane's data. `rd_crc_ok` is cleared on every accepted start, and it stays low after a write.
- R7: A written block is framed as follows: one start bit of 0, then the payload, then 16 CRC bits per lane (MSB first), then one end bit of 1. The engine drives the DAT lines only during these bits.
- R8: Before each written block, the DAT lines stay released for exactly `nwr_gap` cycles (for values of 1 or more). This is counted from start acceptance for the first block, and from DAT0 going high for later blocks.
- R9: After a written block, the engine waits for a 0 on DAT0. It then samples 3 token bits MSB first and compares them with `tok_exp`. At the end of the write, `wr_crc_ok` is high only if every token matched. It is cleared on start and stays low after a read.
- R10: After a token's end bit, the engine keeps the DAT lines released until DAT0 is sampled high. Only then does it continue.
- R11: `done` is a one-cycle pulse in the cycle in which `busy` first reads low after a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one DAT bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer |
| xfer_wr | input | 1 | Transfer writes to the card |
| xfer_rd | input | 1 | Transfer reads data following a response |
| wide4 | input | 1 | 1 = 4-bit bus, 0 = DAT0 only |
| blk_cnt_m1 | input | 8 | Number of blocks minus one |
| blk_bits | input | 14 | Payload bits plus 15 per active lane |
| nwr_gap | input | 6 | Released cycles before each write block |
| tok_exp | input | 3 | Expected card status token |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | `wr_data` is valid |
| wr_ready | output | 1 | Engine takes `wr_data` this cycle |
| rd_data | output | 8 | Received payload byte |
| rd_valid | output | 1 | `rd_data` is valid for one cycle |
| dat_in | input | 4 | Sampled DAT lines |
| dat_out | output | 4 | DAT line drive values |
| dat_oe | output | 4 | Per-lane drive enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished (one cycle) |
| rd_crc_ok | output | 1 | All read CRCs matched |
| wr_crc_ok | output | 1 | All write tokens matched |

## Verification
The assertions assume that `blk_bits` leaves a whole, nonzero number of payload bytes, and that the card answers on DAT0 when a token or a read start bit is due. They also assume a write source that never starves the engine in mid-block, because a stall freezes the DAT lines. The stimulus derives `blk_bits` from a byte count and the bus width, and keeps `wr_valid` high with the next byte always ready. It uses gaps of one cycle or more, and its card model drives start bits, tokens and busy periods only in the windows in which the engine has released the lines.

// File: rtl/sd_block_mover.sv
module sd_block_mover #(
  parameter int CNT_W = 14,
  parameter int BLK_W = 8,
  parameter int GAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             xfer_wr,
  input  logic             xfer_rd,
  input  logic             wide4,
  input  logic [BLK_W-1:0] blk_cnt_m1,
  input  logic [CNT_W-1:0] blk_bits,
  input  logic [GAP_W-1:0] nwr_gap,
  input  logic [2:0]       tok_exp,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic [3:0]       dat_in,
  output logic [3:0]       dat_out,
  output logic [3:0]       dat_oe,
  output logic             busy,
  output logic             done,
  output logic             rd_crc_ok,
  output logic             wr_crc_ok
);
  localparam int FETCH_W = CNT_W + BLK_W;

  typedef enum logic [3:0] {
    S_IDLE, S_GAP, S_START, S_RSTART, S_DATA, S_CRC, S_ENDB,
    S_TOK, S_TOKB, S_TOKE, S_BUSYW
  } st_t;

  st_t                st;
  logic               wr_q, w4_q, hold_v, err;
  logic [2:0]         tok_exp_q, tok, sl;
  logic [GAP_W-1:0]   gap_q;
  logic [CNT_W-1:0]   dcyc_q, cnt;
  logic [BLK_W-1:0]   blk_left;
  logic [7:0]         sh, hold;
  logic [FETCH_W-1:0] fetch_left;
  logic [15:0]        crc [4];

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    crc_step = {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
  endfunction

  wire accept = start && (st == S_IDLE) && (xfer_wr ^ xfer_rd);
  wire [CNT_W-1:0] payload = blk_bits - (wide4 ? CNT_W'(60) : CNT_W'(15));
  wire [CNT_W-1:0] dcyc_in = wide4 ? (payload >> 2) : payload;
  wire [FETCH_W-1:0] total_in = FETCH_W'(payload >> 3) * (FETCH_W'(blk_cnt_m1) + FETCH_W'(1));

  wire [3:0] lanes     = w4_q ? 4'hF : 4'h1;
  wire       last_slot = w4_q ? (sl == 3'd1) : (sl == 3'd7);
  wire       need_byte = wr_q && ((st == S_START) || (st == S_DATA && last_slot && cnt != '0));
  wire       stall     = need_byte && !hold_v;
  wire [3:0] tx_bits   = w4_q ? sh[7:4] : {3'b111, sh[7]};
  wire [3:0] crc_msb   = w4_q ? {crc[3][15], crc[2][15], crc[1][15], crc[0][15]} : {3'b111, crc[0][15]};
  wire [3:0] lane_bits = wr_q ? tx_bits : dat_in;
  wire [7:0] rx_sh     = w4_q ? {sh[3:0], dat_in} : {sh[6:0], dat_in[0]};
  wire       rx_start  = w4_q ? (dat_in == 4'h0) : !dat_in[0];
  wire       crc_zero  = w4_q ? ((crc[0] | crc[1] | crc[2] | crc[3]) == 16'h0) : (crc[0] == 16'h0);
  wire [3:0] drv       = wr_q ? lanes : 4'h0;

  assign busy     = (st != S_IDLE);
  assign wr_ready = wr_q && busy && !hold_v && (fetch_left != '0);

  always_comb begin
    dat_out = 4'hF;
    dat_oe  = 4'h0;
    case (st)
      S_START: begin dat_out = 4'h0;    dat_oe = hold_v ? drv : 4'h0; end
      S_DATA:  begin dat_out = tx_bits; dat_oe = drv; end
      S_CRC:   begin dat_out = crc_msb; dat_oe = drv; end
      S_ENDB:  begin dat_out = 4'hF;    dat_oe = drv; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; wr_q <= 1'b0; w4_q <= 1'b0; hold_v <= 1'b0; err <= 1'b0;
      tok_exp_q <= '0; tok <= '0; sl <= '0; gap_q <= '0; dcyc_q <= '0; cnt <= '0;
      blk_left <= '0; sh <= '0; hold <= '0; fetch_left <= '0;
      rd_data <= '0; rd_valid <= 1'b0; done <= 1'b0; rd_crc_ok <= 1'b0; wr_crc_ok <= 1'b0;
      for (int l = 0; l < 4; l++) crc[l] <= '0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      if (wr_ready && wr_valid) begin
        hold       <= wr_data;
        hold_v     <= 1'b1;
        fetch_left <= fetch_left - FETCH_W'(1);
      end
      case (st)
        S_IDLE: if (accept) begin
          wr_q <= xfer_wr; w4_q <= wide4; tok_exp_q <= tok_exp; gap_q <= nwr_gap;
          dcyc_q <= dcyc_in; blk_left <= blk_cnt_m1; err <= 1'b0; hold_v <= 1'b0;
          rd_crc_ok <= 1'b0; wr_crc_ok <= 1'b0;
          fetch_left <= xfer_wr ? total_in : '0;
          cnt <= CNT_W'(nwr_gap) - CNT_W'(1);
          if (xfer_wr) st <= (nwr_gap == '0) ? S_START : S_GAP;
          else         st <= S_RSTART;
        end
        S_GAP:
          if (cnt == '0) st <= S_START;
          else           cnt <= cnt - CNT_W'(1);
        S_START: if (hold_v) begin
          st <= S_DATA; cnt <= dcyc_q - CNT_W'(1); sl <= '0;
          sh <= hold; hold_v <= 1'b0;
          for (int l = 0; l < 4; l++) crc[l] <= '0;
        end
        S_RSTART: if (rx_start) begin
          st <= S_DATA; cnt <= dcyc_q - CNT_W'(1); sl <= '0;
          for (int l = 0; l < 4; l++) crc[l] <= '0;
        end
        S_DATA: if (!stall) begin
          for (int l = 0; l < 4; l++) crc[l] <= crc_step(crc[l], lane_bits[l]);
          sl <= last_slot ? 3'd0 : sl + 3'd1;
          if (wr_q) begin
            if (last_slot) begin
              if (cnt != '0) begin sh <= hold; hold_v <= 1'b0; end
            end else begin
              sh <= w4_q ? {sh[3:0], 4'h0} : {sh[6:0], 1'b0};
            end
          end else begin
            sh <= rx_sh;
            if (last_slot) begin rd_data <= rx_sh; rd_valid <= 1'b1; end
          end
          if (cnt == '0) begin st <= S_CRC; cnt <= CNT_W'(15); end
          else           cnt <= cnt - CNT_W'(1);
        end
        S_CRC: begin
          for (int l = 0; l < 4; l++)
            crc[l] <= wr_q ? {crc[l][14:0], 1'b0} : crc_step(crc[l], dat_in[l]);
          if (cnt == '0) st <= S_ENDB;
          else           cnt <= cnt - CNT_W'(1);
        end
        S_ENDB:
          if (wr_q) st <= S_TOK;
          else begin
            if (!crc_zero) err <= 1'b1;
            if (blk_left == '0) begin
              st <= S_IDLE; done <= 1'b1; rd_crc_ok <= !err && crc_zero;
            end else begin
              blk_left <= blk_left - BLK_W'(1); st <= S_RSTART;
            end
          end
        S_TOK: if (!dat_in[0]) begin st <= S_TOKB; cnt <= CNT_W'(2); end
        S_TOKB: begin
          tok <= {tok[1:0], dat_in[0]};
          if (cnt == '0) st <= S_TOKE;
          else           cnt <= cnt - CNT_W'(1);
        end
        S_TOKE: begin
          if (tok != tok_exp_q) err <= 1'b1;
          st <= S_BUSYW;
        end
        S_BUSYW: if (dat_in[0]) begin
          if (blk_left == '0) begin
            st <= S_IDLE; done <= 1'b1; wr_crc_ok <= !err;
          end else begin
            blk_left <= blk_left - BLK_W'(1);
            cnt <= CNT_W'(gap_q) - CNT_W'(1);
            st <= (gap_q == '0) ? S_START : S_GAP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_block_mover_chk.sv
module sd_block_mover_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       xfer_wr,
  input logic       xfer_rd,
  input logic       busy,
  input logic       done,
  input logic [3:0] dat_oe,
  input logic       rd_valid,
  input logic       wr_ready,
  input logic       rd_crc_ok,
  input logic       wr_crc_ok
);
  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (xfer_wr ^ xfer_rd)) |=> busy);
  assert_ignore_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(start && (xfer_wr ^ xfer_rd))) |=> !busy);
  assert_lane_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_oe == 4'h0) || (dat_oe == 4'h1) || (dat_oe == 4'hF));
  assert_release_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dat_oe == 4'h0));
  assert_rd_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (busy && !wr_ready));
  assert_fetch_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> busy);
  assert_status_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_crc_ok && wr_crc_ok));
  assert_done_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind sd_block_mover sd_block_mover_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .xfer_wr(xfer_wr), .xfer_rd(xfer_rd),
  .busy(busy), .done(done), .dat_oe(dat_oe), .rd_valid(rd_valid), .wr_ready(wr_ready),
  .rd_crc_ok(rd_crc_ok), .wr_crc_ok(wr_crc_ok)
);

// File: tb/test_sd_block_mover.sv
`timescale 1ns/1ps
module test_sd_block_mover;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, xfer_wr = 1'b0, xfer_rd = 1'b0, wide4 = 1'b0;
  logic [7:0] blk_cnt_m1 = '0;
  logic [13:0] blk_bits = '0;
  logic [5:0] nwr_gap = '0;
  logic [2:0] tok_exp = 3'b010;
  logic [7:0] wr_data;
  logic wr_valid = 1'b1, wr_ready, rd_valid, busy, done, rd_crc_ok, wr_crc_ok;
  logic [7:0] rd_data;
  logic [3:0] dat_in = 4'hF, dat_out, dat_oe;

  logic [7:0] mem [0:4095];
  logic [7:0] got [0:4095];
  int got_n = 0, src_idx = 0, checks = 0, errors = 0;

  always #10 clk = ~clk;
  assign wr_data = mem[src_idx];
  always @(posedge clk) if (wr_ready && wr_valid) src_idx <= src_idx + 1;
  always @(negedge clk) if (rd_valid) begin got[got_n] = rd_data; got_n = got_n + 1; end

  sd_block_mover i_sd_block_mover (.*);

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    crc_step = {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic kick(input bit wr, input bit rd, input bit w4, input int nblk, input int nbytes, input int gap);
    @(negedge clk);
    xfer_wr = wr; xfer_rd = rd; wide4 = w4;
    blk_cnt_m1 = 8'(nblk - 1);
    blk_bits = 14'(nbytes * 8 + (w4 ? 60 : 15));
    nwr_gap = 6'(gap);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_read(input bit w4, input int nblk, input int nbytes, input int bad_blk, input int bad_lane);
    int n = nblk * nbytes, bad = 0;
    logic [15:0] cl [4];
    logic [3:0] v;
    logic [7:0] by;
    for (int i = 0; i < n; i++) mem[i] = 8'($urandom);
    got_n = 0;
    kick(1'b0, 1'b1, w4, nblk, nbytes, 2);
    chk(busy == 1'b1, "R1", "read accepted", busy, 1);
    for (int b = 0; b < nblk; b++) begin
      for (int l = 0; l < 4; l++) cl[l] = 16'h0;
      repeat ($urandom % 3) begin dat_in = 4'hF; @(negedge clk); end
      dat_in = w4 ? 4'h0 : 4'hE; @(negedge clk);
      for (int i = 0; i < nbytes; i++) begin
        by = mem[b * nbytes + i];
        if (w4) begin
          for (int h = 1; h >= 0; h--) begin
            v = h ? by[7:4] : by[3:0];
            for (int l = 0; l < 4; l++) cl[l] = crc_step(cl[l], v[l]);
            dat_in = v; @(negedge clk);
          end
        end else begin
          for (int k = 7; k >= 0; k--) begin
            cl[0] = crc_step(cl[0], by[k]);
            dat_in = {3'b111, by[k]}; @(negedge clk);
          end
        end
      end
      for (int k = 15; k >= 0; k--) begin
        v = {cl[3][k], cl[2][k], cl[1][k], cl[0][k]};
        if (b == bad_blk && k == 5) v[bad_lane] = ~v[bad_lane];
        dat_in = w4 ? v : {3'b111, v[0]}; @(negedge clk);
      end
      dat_in = 4'hF; @(negedge clk);
    end
    chk(done == 1'b1 && busy == 1'b0, "R11", "read done pulse", {done, busy}, 2);
    chk(rd_crc_ok == (bad_blk < 0), "R6", "rd_crc_ok", rd_crc_ok, (bad_blk < 0));
    chk(wr_crc_ok == 1'b0, "R9", "wr_crc_ok after read", wr_crc_ok, 0);
    chk(got_n == n, "R2", "read byte count", got_n, n);
    for (int i = 0; i < n && i < got_n; i++) if (got[i] !== mem[i]) bad++;
    chk(bad == 0, "R5", "read bytes mismatching (R4 lane order)", bad, 0);
    @(negedge clk);
    chk(done == 1'b0, "R11", "done one cycle", done, 0);
  endtask

  task automatic do_write(input bit w4, input int nblk, input int nbytes, input int gap, input int bad_blk, input int busy_n);
    int n = nblk * nbytes, dbad = 0, cbad = 0, obad = 0, g;
    logic [3:0] mask = w4 ? 4'hF : 4'h1, c1;
    logic [15:0] cl [4], cap [4];
    logic [7:0] by, ex;
    logic [2:0] t;
    for (int i = 0; i < n; i++) mem[i] = 8'($urandom);
    src_idx = 0;
    kick(1'b1, 1'b0, w4, nblk, nbytes, gap);
    for (int b = 0; b < nblk; b++) begin
      g = 0;
      while (dat_oe == 4'h0 && g < 100) begin g++; @(negedge clk); end
      chk(g == gap, "R8", "released cycles before block", g, gap);
      chk(dat_oe == mask && (dat_out & mask) == 4'h0, "R7", "start bit", {dat_oe, dat_out}, {mask, 4'h0});
      @(negedge clk);
      for (int l = 0; l < 4; l++) cl[l] = 16'h0;
      for (int i = 0; i < nbytes; i++) begin
        ex = mem[b * nbytes + i];
        if (dat_oe != mask) obad++;
        if (w4) begin
          c1 = dat_out; @(negedge clk);
          by = {c1, dat_out}; @(negedge clk);
          for (int h = 1; h >= 0; h--)
            for (int l = 0; l < 4; l++) cl[l] = crc_step(cl[l], h ? ex[4 + l] : ex[l]);
        end else begin
          for (int k = 7; k >= 0; k--) begin
            by = {by[6:0], dat_out[0]}; cl[0] = crc_step(cl[0], ex[k]); @(negedge clk);
          end
        end
        if (by !== ex) dbad++;
      end
      for (int l = 0; l < 4; l++) cap[l] = 16'h0;
      for (int k = 0; k < 16; k++) begin
        for (int l = 0; l < 4; l++) cap[l] = {cap[l][14:0], dat_out[l]};
        @(negedge clk);
      end
      for (int l = 0; l < 4; l++) if (mask[l] && cap[l] !== cl[l]) cbad++;
      chk(dat_oe == mask && (dat_out & mask) == mask, "R7", "end bit", {dat_oe, dat_out}, {mask, mask});
      @(negedge clk);
      chk(dat_oe == 4'h0, "R9", "bus released for token", dat_oe, 0);
      t = (b == bad_blk) ? 3'b110 : 3'b010;
      dat_in = 4'hE; @(negedge clk);
      for (int k = 2; k >= 0; k--) begin dat_in = {3'b111, t[k]}; @(negedge clk); end
      dat_in = 4'hF; @(negedge clk);
      for (int j = 0; j < busy_n; j++) begin
        dat_in = 4'hE; @(negedge clk);
        if (dat_oe != 4'h0 || busy != 1'b1) obad++;
      end
      dat_in = 4'hF; @(negedge clk);
    end
    chk(done == 1'b1 && busy == 1'b0, "R11", "write done pulse", {done, busy}, 2);
    chk(wr_crc_ok == (bad_blk < 0), "R9", "wr_crc_ok", wr_crc_ok, (bad_blk < 0));
    chk(rd_crc_ok == 1'b0, "R6", "rd_crc_ok after write", rd_crc_ok, 0);
    chk(src_idx == n, "R3", "bytes pulled", src_idx, n);
    chk(dbad == 0, "R4", "write bytes mismatching", dbad, 0);
    chk(cbad == 0, "R7", "CRC lanes mismatching", cbad, 0);
    chk(obad == 0, "R10", "drive errors during data or busy", obad, 0);
    @(negedge clk);
    chk(done == 1'b0, "R11", "done one cycle", done, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && dat_oe == 0 && done == 0, "R1", "reset idle", {busy, dat_oe, done}, 0);
    chk(wr_ready == 0 && rd_valid == 0, "R3", "reset handshake", {wr_ready, rd_valid}, 0);
    chk(rd_crc_ok == 0 && wr_crc_ok == 0, "R6", "reset status", {rd_crc_ok, wr_crc_ok}, 0);
    // R1: both or neither direction bit set
    xfer_wr = 1; xfer_rd = 1; start = 1; @(negedge clk); start = 0; @(negedge clk);
    chk(busy == 0 && dat_oe == 0, "R1", "start with both bits ignored", {busy, dat_oe}, 0);
    xfer_wr = 0; xfer_rd = 0; start = 1; @(negedge clk); start = 0; @(negedge clk);
    chk(busy == 0 && dat_oe == 0, "R1", "start with no bit ignored", {busy, dat_oe}, 0);
    do_read(1'b1, 2, 4, -1, 0);
    do_read(1'b0, 1, 3, -1, 0);
    do_read(1'b1, 3, 2, 1, 3);
    do_read(1'b0, 2, 2, 0, 0);
    do_write(1'b1, 2, 4, 2, -1, 2);
    do_write(1'b0, 1, 3, 1, -1, 0);
    do_write(1'b1, 3, 2, 3, 1, 1);
    do_read(1'b1, 256, 1, -1, 0);
    for (int r = 0; r < 8; r++) begin
      if ($urandom % 2) do_write(1'($urandom), 1 + $urandom % 4, 1 + $urandom % 12, 1 + $urandom % 4, -1, $urandom % 4);
      else              do_read(1'($urandom), 1 + $urandom % 4, 1 + $urandom % 12, -1, 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule